// File: doc/BRIEF.md
# Pixel Array Scan Sequencer

This block walks an 8 by 8 pixel array one pixel at a time and turns the selected column bit of each pixel into one serial digital stream. It keeps a 6-bit pixel address: the upper three bits become a one-hot row select, and the lower three bits pick the column whose data bit drives the serial output. A frame is therefore 64 serial bits, one per pixel.

The block makes its own stepping strobe from the system clock. Each pixel is held for a dwell time that depends on where the scan is. The first pixel of a frame waits the longest so that every pixel can settle. The first pixel of each later row waits a medium time so that the column processing can follow the new row. Every other column step waits the shortest time. A frame starts with a quiet pre-roll, lasting two short step periods, in which no row is driven. Once the pixel is stable, a pixel-valid strobe marks the last cycle of each dwell. A one-cycle frame-done flag follows the 64th pixel. A mode input selects how a frame is launched. In full-control mode a start pulse launches it. In reduced-pin mode the launch comes from the global reset alone.

Top module: `pixel_scan_sequencer`

## Requirements
- R1: Pixels are presented in address order 0 to 63, with the row given by address bits [5:3] and the scan column by bits [2:0]. The row and column outputs hold steady between pixel-valid strobes, and one frame has exactly 64 pixel-valid strobes.
- R2: `row_sel` has at most one bit set at any time. Bit r is set only while a pixel of row r is presented, and no bit is set outside a scan.
- R3: While a pixel is presented, `ser_out` equals `col_data[col_idx]`. At all other times `ser_out` is 0.
- R4: After a launch, the block spends exactly 2·DW_COL cycles in a pre-roll with `row_sel` all zero before pixel 0 is presented.
- R5: Pixel 0 of a frame is presented for DW_FIRST cycles.
- R6: The first pixel of each of rows 1 to 7 (column position 0) is presented for DW_ROW cycles.
- R7: Every other pixel is presented for DW_COL cycles.
- R8: `pix_valid` is high only during the last cycle of each pixel's dwell and never outside a scan.
- R9: In the cycle after the last pixel's `pix_valid`, `frame_done` is high for exactly one cycle with `row_sel` all zero. The block then stays idle until the next launch, and a launch seen in the `frame_done` cycle is accepted.
- R10: With `full_mode` = 1, a `start` pulse sampled while idle launches a frame. No frame starts without one, and `start` during a frame has no effect.
- R11: With `full_mode` = 0, a frame is launched on the first clock edge after `rst_n` is released, and `start` has no effect.
- R12: With COL_DESCEND = 1, `col_idx` runs 7 down to 0 within each row; with 0 it runs 0 up to 7.
- R13: While `rst_n` is low, `row_sel`, `col_idx`, `ser_out`, `pix_valid` and `frame_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| start | input | 1 | Frame launch pulse, used in full-control mode |
| full_mode | input | 1 | 1 = full-control mode, 0 = reduced-pin mode |
| col_data | input | 8 | Digitised column bits, bit c belongs to column c |
| row_sel | output | 8 | One-hot row select lines |
| col_idx | output | 3 | Column currently routed to the serial output |
| ser_out | output | 1 | Serial digital pixel output |
| pix_valid | output | 1 | High in the last cycle of each pixel dwell |
| frame_done | output | 1 | One-cycle pulse after the 64th pixel |

## Verification
Two events can land in the same cycle: the end of a frame, shown by `frame_done`, and a new launch. The bench waits until it sees `frame_done` and raises `start` within that same cycle. It then expects the next frame to begin at once, with its full pre-roll of exactly 2·DW_COL quiet cycles. A reference model with its own counters follows both paths every cycle and flags any missed or delayed launch. The same model also covers a `start` pulse that falls mid-frame, which must leave every dwell length unchanged.

// File: rtl/pss_pkg.sv
package pss_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_SCAN = 2'd2
  } pss_phase_e;

  // Largest of three unsigned values, used to size the dwell counter.
  function automatic int unsigned pss_max3(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Dwell length for the pixel that is about to be presented.
  function automatic int unsigned pss_step_len(input int unsigned next_col,
                                               input int unsigned row_len,
                                               input int unsigned col_len);
    return (next_col == 0) ? row_len : col_len;
  endfunction

  // Map an ascending scan position onto the physical column number.
  function automatic int unsigned pss_col_order(input int unsigned pos,
                                                input int unsigned cols,
                                                input bit          desc);
    return desc ? (cols - 1 - pos) : pos;
  endfunction

endpackage

// File: rtl/pss_dwell_timer.sv
module pss_dwell_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/pss_scan_ctrl.sv
module pss_scan_ctrl
  import pss_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int COL_BITS = 3,
  parameter int CNT_W    = 9,
  parameter int DW_FIRST = 274,
  parameter int DW_ROW   = 108,
  parameter int DW_COL   = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full_mode,
  input  logic              start,
  input  logic              expired,
  output pss_phase_e        phase,
  output logic [ADDR_W-1:0] addr,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output logic              frame_done,
  output logic              launch
);

  localparam int          PRE_LEN   = 2 * DW_COL;
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  pss_phase_e        phase_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q;
  logic              pend_q;

  logic [ADDR_W-1:0]   next_addr;
  logic [COL_BITS-1:0] next_col;
  logic                at_last;

  assign next_addr = addr_q + 1'b1;
  assign next_col  = next_addr[COL_BITS-1:0];
  assign at_last   = (addr_q == LAST_ADDR);

  // Launch source: external pulse in full mode, reset release otherwise.
  assign launch = (phase_q == PH_IDLE) && (full_mode ? start : pend_q);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (phase_q)
      PH_IDLE: begin
        tmr_load = launch;
        tmr_val  = CNT_W'(PRE_LEN - 1);
      end
      PH_PRE: begin
        tmr_load = expired;
        tmr_val  = CNT_W'(DW_FIRST - 1);
      end
      PH_SCAN: begin
        tmr_load = expired && !at_last;
        tmr_val  = CNT_W'(pss_step_len(int'(next_col), DW_ROW, DW_COL) - 1);
      end
      default: begin
        tmr_load = 1'b0;
        tmr_val  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      addr_q  <= '0;
      done_q  <= 1'b0;
      pend_q  <= 1'b1;
    end else begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (launch) phase_q <= PH_PRE;
        end
        PH_PRE: begin
          if (expired) begin
            phase_q <= PH_SCAN;
            addr_q  <= '0;
          end
        end
        PH_SCAN: begin
          if (expired) begin
            if (at_last) begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end else begin
              addr_q <= next_addr;
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase      = phase_q;
  assign addr       = addr_q;
  assign frame_done = done_q;

endmodule

// File: rtl/pss_row_decoder.sv
module pss_row_decoder #(
  parameter int ROW_BITS = 3,
  parameter int ROWS     = 8
) (
  input  logic                en,
  input  logic [ROW_BITS-1:0] row_addr,
  output logic [ROWS-1:0]     row_sel
);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_sel[r] = en && (row_addr == ROW_BITS'(r));
  end

endmodule

// File: rtl/pss_col_select.sv
module pss_col_select
  import pss_pkg::*;
#(
  parameter int COL_BITS    = 3,
  parameter int COLS        = 8,
  parameter bit COL_DESCEND = 1'b0
) (
  input  logic                en,
  input  logic [COL_BITS-1:0] scan_pos,
  input  logic [COLS-1:0]     col_data,
  output logic [COL_BITS-1:0] col_idx,
  output logic                ser_out
);

  logic [COL_BITS-1:0] phys_col;

  if (COL_DESCEND) begin : g_desc
    assign phys_col = COL_BITS'(pss_col_order(int'(scan_pos), COLS, 1'b1));
  end else begin : g_asc
    assign phys_col = scan_pos;
  end

  logic [COLS-1:0] pick;
  for (genvar c = 0; c < COLS; c++) begin : g_pick
    assign pick[c] = col_data[c] && (phys_col == COL_BITS'(c));
  end

  assign col_idx = en ? phys_col : '0;
  assign ser_out = en && (|pick);

endmodule

// File: rtl/pixel_scan_sequencer.sv
module pixel_scan_sequencer
  import pss_pkg::*;
#(
  parameter int ROW_BITS    = 3,
  parameter int COL_BITS    = 3,
  parameter int DW_FIRST    = 274,
  parameter int DW_ROW      = 108,
  parameter int DW_COL      = 27,
  parameter bit COL_DESCEND = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       full_mode,
  input  logic [(1<<COL_BITS)-1:0]   col_data,
  output logic [(1<<ROW_BITS)-1:0]   row_sel,
  output logic [COL_BITS-1:0]        col_idx,
  output logic                       ser_out,
  output logic                       pix_valid,
  output logic                       frame_done
);

  localparam int ROWS   = 1 << ROW_BITS;
  localparam int COLS   = 1 << COL_BITS;
  localparam int ADDR_W = ROW_BITS + COL_BITS;
  localparam int MAX_DW = int'(pss_max3(2 * DW_COL, DW_FIRST, DW_ROW));
  localparam int CNT_W  = $clog2(MAX_DW + 1);

  pss_phase_e        phase;
  logic [ADDR_W-1:0] addr;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_expired;
  logic              launch;

  // Named internal events, observed by the bound checker.
  logic in_scan;
  logic in_pre;
  assign in_scan = (phase == PH_SCAN);
  assign in_pre  = (phase == PH_PRE);

  pss_dwell_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  pss_scan_ctrl #(
    .ADDR_W   (ADDR_W),
    .COL_BITS (COL_BITS),
    .CNT_W    (CNT_W),
    .DW_FIRST (DW_FIRST),
    .DW_ROW   (DW_ROW),
    .DW_COL   (DW_COL)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .full_mode  (full_mode),
    .start      (start),
    .expired    (tmr_expired),
    .phase      (phase),
    .addr       (addr),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .frame_done (frame_done),
    .launch     (launch)
  );

  pss_row_decoder #(
    .ROW_BITS (ROW_BITS),
    .ROWS     (ROWS)
  ) u_rows (
    .en       (in_scan),
    .row_addr (addr[ADDR_W-1:COL_BITS]),
    .row_sel  (row_sel)
  );

  pss_col_select #(
    .COL_BITS    (COL_BITS),
    .COLS        (COLS),
    .COL_DESCEND (COL_DESCEND)
  ) u_cols (
    .en       (in_scan),
    .scan_pos (addr[COL_BITS-1:0]),
    .col_data (col_data),
    .col_idx  (col_idx),
    .ser_out  (ser_out)
  );

  assign pix_valid = in_scan && tmr_expired;

endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
  parameter int ROWS     = 8,
  parameter int COL_BITS = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ROWS-1:0]     row_sel,
  input logic [COL_BITS-1:0] col_idx,
  input logic                ser_out,
  input logic                pix_valid,
  input logic                frame_done,
  input logic                in_pre,
  input logic                launch
);

  AST_ROW_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(row_sel)); // R2

  AST_SER_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (row_sel == '0) |-> !ser_out); // R3

  AST_PRE_ROWS_OFF: assert property (@(posedge clk) disable iff (!rst_n) in_pre |-> (row_sel == '0)); // R4

  AST_VALID_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n) pix_valid |-> (row_sel != '0)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) frame_done |=> !frame_done); // R9

  AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n) frame_done |-> ($past(pix_valid) && (row_sel == '0))); // R9

  AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ((row_sel != '0) && !pix_valid) |=> $stable(col_idx)); // R1

  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ((row_sel != '0) && !pix_valid) |=> $stable(row_sel)); // R1

  AST_LAUNCH_TO_PRE: assert property (@(posedge clk) disable iff (!rst_n) launch |=> in_pre); // R10

endmodule

bind pixel_scan_sequencer pss_checker #(
  .ROWS     (ROWS),
  .COL_BITS (COL_BITS)
) u_pss_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .row_sel    (row_sel),
  .col_idx    (col_idx),
  .ser_out    (ser_out),
  .pix_valid  (pix_valid),
  .frame_done (frame_done),
  .in_pre     (in_pre),
  .launch     (launch)
);

// File: tb/pixel_scan_sequencer_bench.sv
`timescale 1ns/1ps
module pixel_scan_sequencer_bench;

  localparam int F = 9;
  localparam int R = 5;
  localparam int C = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       full_mode = 1'b0;
  logic [7:0] col_data = 8'h00;

  logic [7:0] row_a, row_d;
  logic [2:0] col_a, col_d;
  logic       ser_a, ser_d, val_a, val_d, done_a, done_d;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pixel_scan_sequencer #(
    .DW_FIRST(F), .DW_ROW(R), .DW_COL(C), .COL_DESCEND(1'b0)
  ) u_pixel_scan_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .full_mode(full_mode),
    .col_data(col_data), .row_sel(row_a), .col_idx(col_a), .ser_out(ser_a),
    .pix_valid(val_a), .frame_done(done_a)
  );

  pixel_scan_sequencer #(
    .DW_FIRST(F), .DW_ROW(R), .DW_COL(C), .COL_DESCEND(1'b1)
  ) u_pixel_scan_sequencer_desc (
    .clk(clk), .rst_n(rst_n), .start(start), .full_mode(full_mode),
    .col_data(col_data), .row_sel(row_d), .col_idx(col_d), .ser_out(ser_d),
    .pix_valid(val_d), .frame_done(done_d)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 pre-roll, 2 scanning.
  int m_ph, m_rem, m_idx;
  bit m_done, m_pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_rem = 0; m_idx = 0; m_done = 0; m_pend = 1;
    end else begin
      bit go;
      bit nd;
      go = (m_ph == 0) && (full_mode ? start : m_pend);
      m_pend = 0;
      nd = 0;
      if (m_ph == 0) begin
        if (go) begin m_ph = 1; m_rem = 2 * C; end
      end else if (m_ph == 1) begin
        if (m_rem == 1) begin m_ph = 2; m_idx = 0; m_rem = F; end
        else m_rem--;
      end else begin
        if (m_rem == 1) begin
          if (m_idx == 63) begin m_ph = 0; nd = 1; end
          else begin
            m_idx++;
            m_rem = (m_idx % 8 == 0) ? R : C;
          end
        end else m_rem--;
      end
      m_done = nd;
    end
  end

  // Per-cycle comparison plus an independent dwell monitor.
  int gap = 0;
  int vcount = 0;

  always @(negedge clk) begin
    logic [7:0] e_row;
    int e_ca, e_cd;
    bit e_val, e_sa, e_sd;
    e_row = (m_ph == 2) ? (8'b1 << (m_idx / 8)) : 8'h00;
    e_ca  = (m_ph == 2) ? (m_idx % 8) : 0;
    e_cd  = (m_ph == 2) ? (7 - m_idx % 8) : 0;
    e_val = (m_ph == 2) && (m_rem == 1);
    e_sa  = (m_ph == 2) ? col_data[e_ca] : 1'b0;
    e_sd  = (m_ph == 2) ? col_data[e_cd] : 1'b0;
    chk(row_a == e_row, "R2", "row_sel", int'(row_a), int'(e_row));
    chk(int'(col_a) == e_ca, "R1", "col_idx asc", int'(col_a), e_ca);
    chk(int'(col_d) == e_cd, "R12", "col_idx desc", int'(col_d), e_cd);
    chk(val_a == e_val && val_d == e_val, "R8", "pix_valid", int'(val_a), int'(e_val));
    chk(ser_a == e_sa, "R3", "ser_out asc", int'(ser_a), int'(e_sa));
    chk(ser_d == e_sd, "R3", "ser_out desc", int'(ser_d), int'(e_sd));
    chk(done_a == m_done && done_d == m_done, "R9", "frame_done", int'(done_a), int'(m_done));

    if (!rst_n) begin
      gap = 0; vcount = 0;
    end else begin
      if (row_a != 8'h00) begin
        gap++;
        if (val_a) begin
          if (vcount == 0)
            chk(gap == F, "R5", "first pixel dwell", gap, F);
          else if (vcount % 8 == 0)
            chk(gap == R, "R6", "row start dwell", gap, R);
          else
            chk(gap == C, "R7", "column dwell", gap, C);
          vcount++;
          gap = 0;
        end
      end
      if (done_a) begin
        chk(vcount == 64, "R1", "strobes per frame", vcount, 64);
        chk(row_a == 8'h00, "R9", "rows off at frame end", int'(row_a), 0);
        vcount = 0;
      end
    end
  end

  // Column data changes every cycle so the serial path sees many patterns.
  initial begin
    int unsigned seed = 32'h1234_5678;
    forever begin
      @(posedge clk); #1;
      seed = seed * 32'd1103515245 + 32'd12345;
      col_data = seed[23:16];
    end
  end

  task automatic measure_pre(input string req);
    int n = 0;
    forever begin
      @(negedge clk);
      if (row_a != 8'h00) break;
      n++;
    end
    chk(n == 2 * C, req, "pre-roll length", n, 2 * C);
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done_a);
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  initial begin
    // Reset state (R13)
    repeat (3) @(negedge clk);
    chk(row_a == 0 && val_a == 0 && done_a == 0 && ser_a == 0 && col_a == 0,
        "R13", "outputs in reset", int'(row_a), 0);

    // Reduced-pin mode: launch comes from reset release (R11, R4)
    @(negedge clk); #1 rst_n = 1'b1;
    measure_pre("R11");
    repeat (20) @(negedge clk);
    pulse_start();
    wait_done();
    pulse_start();
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (row_a != 8'h00) quiet = 1'b0;
      end
      chk(quiet, "R11", "start ignored in reduced mode", int'(quiet), 1);
    end

    // Full-control mode: idle until start (R10)
    @(posedge clk); #1 rst_n = 1'b0; full_mode = 1'b1;
    repeat (3) @(negedge clk);
    chk(row_a == 0 && val_a == 0 && done_a == 0, "R13", "outputs in second reset", int'(row_a), 0);
    #1 rst_n = 1'b1;
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (row_a != 8'h00) quiet = 1'b0;
      end
      chk(quiet, "R10", "no frame without start", int'(quiet), 1);
    end
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    measure_pre("R4");
    repeat (40) @(negedge clk);
    pulse_start();
    wait_done();

    // Launch in the frame_done cycle is accepted at once (R9, R10)
    start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    measure_pre("R9");
    wait_done();
    repeat (5) @(negedge clk);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule